// File: doc/BRIEF.md
# PWM Event Trigger Prescaler

This block sits next to a PWM time-base counter and turns the counter's single-cycle event pulses into three outputs. The outputs are an interrupt request and two ADC start-of-conversion strobes, called A and B. The inputs are five kinds of pulse: counter at zero, counter at period, compare matches A to D for each count direction, two digital-compare SOC inputs and a sync pulse.

Each channel picks its own trigger source and counts how often that source occurs. It fires when the count reaches a programmed period of 1 to 15. The event counter saturates at 15. Each channel has a status flag, a software clear, a software force, and an initial count that is loaded on sync or on a software request.

A plain write port sets up the block. A combinational read port returns the configuration, the flags and the live counts.

Top module: `pwm_evt_prescaler`

## Requirements
- R1: After reset, every register reads 0, every count and flag is 0, and all three outputs are low.
- R2: A 4-bit source code per channel is held in register 0, bits [4c+3:4c], with channel 0 = interrupt, 1 = SOC A, 2 = SOC B. The codes are: 0 none, 1 zero, 2 period, 3 zero or period, 4/5 compare A up/down, 6/7 compare B up/down, 8/9 compare C up/down, 10/11 compare D up/down, 12 digital compare, 13 to 15 none. An event that has the wrong direction for the chosen code is not counted.
- R3: Register 1, bits [4c+3:4c], holds the period P of each channel. On the P-th selected event, the output pulses high for exactly one cycle, in the cycle after the event is sampled. In that same clock edge the count returns to 0.
- R4: A channel whose period is 0 keeps its count at 0. It produces no output and does not set its flag, whether the trigger is an event or a force.
- R5: A count loaded above the period keeps rising with each event, stops at 15, and produces no output.
- R6: The flag of a channel sets when the channel fires. Writing 1 to bit c of register 3 clears flag c. If a fire and a clear happen in the same cycle, the flag stays set. Reading register 3 returns the flags in bits [2:0].
- R7: The interrupt output fires only while flag 0 is clear. Once it has fired, it stays silent until software clears the flag. The SOC strobes pulse on every prescaled event, whatever the state of their flags.
- R8: Writing 1 to bit 4+c of register 3 counts as one event of channel c in that cycle.
- R9: Register 2, bits [4c+3:4c], holds the initial count of each channel. The initial count is loaded when the sync input is high and bit c of register 4 is set, or when bit 8+c of register 3 is written as 1. A load takes priority over an event in the same cycle, and the event is lost.
- R10: Register 5, bits [4c+3:4c], returns the current count of channel c.
- R11: Source code 12 makes SOC A follow digital-compare input bit 0 and SOC B follow bit 1. For the interrupt channel, code 12 selects nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| evZero | input | 1 | Pulse: counter equals zero |
| evPrd | input | 1 | Pulse: counter equals period |
| cmpUp | input | 4 | Compare A to D matches (bit 0 = A) while counting up |
| cmpDn | input | 4 | Compare A to D matches while counting down |
| dcSoc | input | 2 | Digital-compare SOC events (bit 0 to SOC A, bit 1 to SOC B) |
| syncIn | input | 1 | Sync pulse that loads the enabled counters |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Write address |
| wrData | input | 12 | Write data |
| rdAddr | input | 3 | Read address |
| rdData | output | 12 | Read data, combinational |
| intOut | output | 1 | Interrupt request pulse |
| socAOut | output | 1 | SOC A strobe |
| socBOut | output | 1 | SOC B strobe |

## Verification
The hardest state to reach is a count above the period, because normal counting clears at the period and never passes it. The stimulus gets there by programming a high initial count and applying a software load. It then feeds events until the counter is pinned at 15. The other two races are reached by driving the event input in the same cycle as a register write. One write clears the flag and the other loads the initial count. The flags and counts are then read back to confirm which side won.

// File: rtl/evtrig_pkg.sv
package evtrig_pkg;
  localparam int NCH  = 3;
  localparam int SELW = 4;

  typedef enum logic [SELW-1:0] {
    SRC_NONE    = 4'd0,
    SRC_ZERO    = 4'd1,
    SRC_PRD     = 4'd2,
    SRC_ZERO_PRD= 4'd3,
    SRC_CA_UP   = 4'd4,
    SRC_CA_DN   = 4'd5,
    SRC_CB_UP   = 4'd6,
    SRC_CB_DN   = 4'd7,
    SRC_CC_UP   = 4'd8,
    SRC_CC_DN   = 4'd9,
    SRC_CD_UP   = 4'd10,
    SRC_CD_DN   = 4'd11,
    SRC_DC      = 4'd12
  } srcSel_e;

  typedef struct packed {
    logic [NCH-1:0] hit;
    logic [NCH-1:0] load;
    logic [NCH-1:0] flagClr;
  } dpStrobe_t;
endpackage

// File: rtl/evtrig_ctrl.sv
module evtrig_ctrl
  import evtrig_pkg::*;
#(
  parameter int CNT_W = 4,
  parameter int DW    = 12,
  parameter int AW    = 3
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      evZero,
  input  logic                      evPrd,
  input  logic [3:0]                cmpUp,
  input  logic [3:0]                cmpDn,
  input  logic [NCH-2:0]            dcSoc,
  input  logic                      syncIn,
  input  logic                      wrEn,
  input  logic [AW-1:0]             wrAddr,
  input  logic [DW-1:0]             wrData,
  input  logic [AW-1:0]             rdAddr,
  output logic [DW-1:0]             rdData,
  input  logic [NCH-1:0][CNT_W-1:0] cnt,
  input  logic [NCH-1:0]            flag,
  output logic [NCH-1:0][CNT_W-1:0] prd,
  output logic [NCH-1:0][CNT_W-1:0] init,
  output dpStrobe_t                 st
);
  localparam logic [AW-1:0] A_SEL  = AW'(0);
  localparam logic [AW-1:0] A_PRD  = AW'(1);
  localparam logic [AW-1:0] A_INIT = AW'(2);
  localparam logic [AW-1:0] A_CTL  = AW'(3);
  localparam logic [AW-1:0] A_SYNC = AW'(4);
  localparam logic [AW-1:0] A_CNT  = AW'(5);
  localparam int CLR_LSB = 0;
  localparam int FRC_LSB = 4;
  localparam int INI_LSB = 8;

  logic [NCH-1:0][SELW-1:0] selReg;
  logic [NCH-1:0]           syncEn;
  logic [NCH-1:0]           hitV, loadV, clrV;
  logic                     wrCtl;

  assign wrCtl = wrEn && (wrAddr == A_CTL);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selReg <= '0;
      prd    <= '0;
      init   <= '0;
      syncEn <= '0;
    end else if (wrEn) begin
      for (int c = 0; c < NCH; c++) begin
        if (wrAddr == A_SEL)  selReg[c] <= wrData[c*SELW +: SELW];
        if (wrAddr == A_PRD)  prd[c]    <= wrData[c*CNT_W +: CNT_W];
        if (wrAddr == A_INIT) init[c]   <= wrData[c*CNT_W +: CNT_W];
        if (wrAddr == A_SYNC) syncEn[c] <= wrData[c];
      end
    end
  end

  for (genvar ch = 0; ch < NCH; ch++) begin : g_src
    logic dcEv, srcEv;
    if (ch == 0) begin : g_nodc
      assign dcEv = 1'b0;
    end else begin : g_dc
      assign dcEv = dcSoc[ch-1];
    end
    always_comb begin
      case (srcSel_e'(selReg[ch]))
        SRC_ZERO:     srcEv = evZero;
        SRC_PRD:      srcEv = evPrd;
        SRC_ZERO_PRD: srcEv = evZero | evPrd;
        SRC_CA_UP:    srcEv = cmpUp[0];
        SRC_CA_DN:    srcEv = cmpDn[0];
        SRC_CB_UP:    srcEv = cmpUp[1];
        SRC_CB_DN:    srcEv = cmpDn[1];
        SRC_CC_UP:    srcEv = cmpUp[2];
        SRC_CC_DN:    srcEv = cmpDn[2];
        SRC_CD_UP:    srcEv = cmpUp[3];
        SRC_CD_DN:    srcEv = cmpDn[3];
        SRC_DC:       srcEv = dcEv;
        default:      srcEv = 1'b0;
      endcase
    end
    assign hitV[ch]  = srcEv | (wrCtl & wrData[FRC_LSB+ch]);
    assign loadV[ch] = (syncIn & syncEn[ch]) | (wrCtl & wrData[INI_LSB+ch]);
    assign clrV[ch]  = wrCtl & wrData[CLR_LSB+ch];
  end

  assign st = '{hit: hitV, load: loadV, flagClr: clrV};

  always_comb begin
    rdData = '0;
    for (int c = 0; c < NCH; c++) begin
      case (rdAddr)
        A_SEL:   rdData[c*SELW +: SELW]   = selReg[c];
        A_PRD:   rdData[c*CNT_W +: CNT_W] = prd[c];
        A_INIT:  rdData[c*CNT_W +: CNT_W] = init[c];
        A_CTL:   rdData[c]                = flag[c];
        A_SYNC:  rdData[c]                = syncEn[c];
        A_CNT:   rdData[c*CNT_W +: CNT_W] = cnt[c];
        default: ;
      endcase
    end
  end

  // a software clear reaches the datapath only through a write to the control address
  AST_CLR_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (|st.flagClr) |-> (wrEn && wrAddr == A_CTL)); // R6
endmodule

// File: rtl/evtrig_dp.sv
module evtrig_dp
  import evtrig_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  dpStrobe_t                 st,
  input  logic [NCH-1:0][CNT_W-1:0] prd,
  input  logic [NCH-1:0][CNT_W-1:0] init,
  output logic [NCH-1:0][CNT_W-1:0] cnt,
  output logic [NCH-1:0]            flag,
  output logic [NCH-1:0]            pulse
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    logic [CNT_W-1:0] nxt;
    logic             fire, enabled, emit;

    assign enabled = (prd[ch] != '0);
    assign nxt     = (cnt[ch] == CNT_MAX) ? CNT_MAX : cnt[ch] + 1'b1;
    assign fire    = enabled && st.hit[ch] && !st.load[ch] && (nxt == prd[ch]);

    if (ch == 0) begin : g_gated
      assign emit = fire & ~flag[ch];
    end else begin : g_free
      assign emit = fire;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        cnt[ch]   <= '0;
        flag[ch]  <= 1'b0;
        pulse[ch] <= 1'b0;
      end else begin
        pulse[ch] <= emit;
        if (fire)                flag[ch] <= 1'b1;
        else if (st.flagClr[ch]) flag[ch] <= 1'b0;
        if (!enabled)            cnt[ch] <= '0;
        else if (st.load[ch])    cnt[ch] <= init[ch];
        else if (fire)           cnt[ch] <= '0;
        else if (st.hit[ch])     cnt[ch] <= nxt;
      end
    end

    AST_PRD_ZERO_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
      (prd[ch] == '0) |=> (cnt[ch] == '0)); // R4
    AST_PULSE_SETS_FLAG: assert property (@(posedge clk) disable iff (!rstN)
      pulse[ch] |-> flag[ch]); // R6
    AST_PULSE_CLEARS_CNT: assert property (@(posedge clk) disable iff (!rstN)
      pulse[ch] |-> (cnt[ch] == '0)); // R3
    AST_SATURATE: assert property (@(posedge clk) disable iff (!rstN)
      (cnt[ch] == CNT_MAX && !st.load[ch] && enabled && prd[ch] != CNT_MAX)
        |=> (cnt[ch] == CNT_MAX)); // R5
    AST_LOAD_VALUE: assert property (@(posedge clk) disable iff (!rstN)
      (st.load[ch] && enabled) |=> (cnt[ch] == $past(init[ch]))); // R9
    if (ch == 0) begin : g_intchk
      AST_INT_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
        pulse[ch] |=> !pulse[ch]); // R7
    end
  end
endmodule

// File: rtl/pwm_evt_prescaler.sv
module pwm_evt_prescaler
  import evtrig_pkg::*;
#(
  parameter int CNT_W = 4,
  parameter int DW    = 12,
  parameter int AW    = 3
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          evZero,
  input  logic          evPrd,
  input  logic [3:0]    cmpUp,
  input  logic [3:0]    cmpDn,
  input  logic [1:0]    dcSoc,
  input  logic          syncIn,
  input  logic          wrEn,
  input  logic [AW-1:0] wrAddr,
  input  logic [DW-1:0] wrData,
  input  logic [AW-1:0] rdAddr,
  output logic [DW-1:0] rdData,
  output logic          intOut,
  output logic          socAOut,
  output logic          socBOut
);
  dpStrobe_t                 st;
  logic [NCH-1:0][CNT_W-1:0] cnt, prd, init;
  logic [NCH-1:0]            flag, pulse;

  evtrig_ctrl #(.CNT_W(CNT_W), .DW(DW), .AW(AW)) u_ctrl (
    .clk(clk), .rstN(rstN), .evZero(evZero), .evPrd(evPrd),
    .cmpUp(cmpUp), .cmpDn(cmpDn), .dcSoc(dcSoc), .syncIn(syncIn),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData),
    .cnt(cnt), .flag(flag), .prd(prd), .init(init), .st(st)
  );

  evtrig_dp #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .st(st), .prd(prd), .init(init),
    .cnt(cnt), .flag(flag), .pulse(pulse)
  );

  assign intOut  = pulse[0];
  assign socAOut = pulse[1];
  assign socBOut = pulse[2];
endmodule

// File: tb/sim_pwm_evt_prescaler.sv
`timescale 1ns/1ps
module sim_pwm_evt_prescaler;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        evZero = 0, evPrd = 0, syncIn = 0, wrEn = 0;
  logic [3:0]  cmpUp = '0, cmpDn = '0;
  logic [1:0]  dcSoc = '0;
  logic [2:0]  wrAddr = '0, rdAddr = '0;
  logic [11:0] wrData = '0;
  logic [11:0] rdData;
  logic        intOut, socAOut, socBOut;

  int checks = 0;
  int errors = 0;
  int cycCnt = 0;
  bit finished = 0;

  typedef struct {int cyc; int ch; string req;} expItem_t;
  expItem_t expQ[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cycCnt <= cycCnt + 1;

  pwm_evt_prescaler u0 (
    .clk(clk), .rstN(rstN), .evZero(evZero), .evPrd(evPrd),
    .cmpUp(cmpUp), .cmpDn(cmpDn), .dcSoc(dcSoc), .syncIn(syncIn),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData), .rdAddr(rdAddr),
    .rdData(rdData), .intOut(intOut), .socAOut(socAOut), .socBOut(socBOut)
  );

  // driver: inputs already set by caller; expected pulses land one cycle later
  task automatic step(input logic [2:0] mask, input string req);
    for (int c = 0; c < 3; c++)
      if (mask[c]) expQ.push_back('{cycCnt + 1, c, req});
    @(posedge clk); #1;
    evZero = 0; evPrd = 0; cmpUp = '0; cmpDn = '0; dcSoc = '0;
    syncIn = 0; wrEn = 0;
  endtask

  task automatic setWr(input logic [2:0] a, input logic [11:0] d);
    wrEn = 1; wrAddr = a; wrData = d;
  endtask

  task automatic wr(input logic [2:0] a, input logic [11:0] d);
    setWr(a, d);
    step(3'b000, "cfg");
  endtask

  task automatic rdChk(input logic [2:0] a, input logic [11:0] exp, input string req);
    rdAddr = a; #0.5;
    checks++;
    if (rdData !== exp) begin
      errors++;
      $display("FAIL %s: reg %0d actual=%h expected=%h", req, a, rdData, exp);
    end
  endtask

  // monitor: compares every output pulse against the scoreboard
  always @(negedge clk) begin
    if (rstN && !finished) begin
      while (expQ.size() > 0 && expQ[0].cyc < cycCnt) begin
        checks++; errors++;
        $display("FAIL %s: ch%0d actual=no pulse expected=pulse at cycle %0d",
                 expQ[0].req, expQ[0].ch, expQ[0].cyc);
        void'(expQ.pop_front());
      end
      for (int c = 0; c < 3; c++) begin
        if ({socBOut, socAOut, intOut}[c]) begin
          checks++;
          if (expQ.size() > 0 && expQ[0].cyc == cycCnt && expQ[0].ch == c)
            void'(expQ.pop_front());
          else begin
            errors++;
            $display("FAIL %s: ch%0d actual=pulse expected=none at cycle %0d",
                     (expQ.size() > 0) ? expQ[0].req : "R3", c, cycCnt);
          end
        end
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    // R1 reset state
    rdChk(3'd0, 12'h000, "R1");
    rdChk(3'd1, 12'h000, "R1");
    rdChk(3'd3, 12'h000, "R1");
    rdChk(3'd5, 12'h000, "R1");

    // ch0 zero/P3, ch1 period/P2, ch2 cmpA up/P1
    wr(3'd0, 12'h421);
    wr(3'd1, 12'h123);
    evZero = 1; step(3'b000, "R3");
    evZero = 1; step(3'b000, "R3");
    rdChk(3'd5, 12'h002, "R10");
    evZero = 1; step(3'b001, "R3");
    rdChk(3'd5, 12'h000, "R3");
    rdChk(3'd3, 12'h001, "R6");
    evPrd = 1; step(3'b000, "R3");
    evPrd = 1; step(3'b010, "R3");
    cmpDn[0] = 1; step(3'b000, "R2");
    rdChk(3'd5, 12'h000, "R2");
    cmpUp[0] = 1; step(3'b100, "R2");
    cmpUp[0] = 1; step(3'b100, "R7");
    // R7 interrupt gated by flag
    evZero = 1; step(3'b000, "R7");
    evZero = 1; step(3'b000, "R7");
    evZero = 1; step(3'b000, "R7");
    rdChk(3'd3, 12'h007, "R6");
    wr(3'd3, 12'h001);
    rdChk(3'd3, 12'h006, "R6");
    evZero = 1; step(3'b000, "R7");
    evZero = 1; step(3'b000, "R7");
    evZero = 1; step(3'b001, "R7");
    // R6 clear and fire in the same cycle
    evPrd = 1; step(3'b000, "R6");
    evPrd = 1; setWr(3'd3, 12'h002); step(3'b010, "R6");
    rdChk(3'd3, 12'h007, "R6");
    wr(3'd3, 12'h002);
    rdChk(3'd3, 12'h005, "R6");
    // R8 software force
    wr(3'd1, 12'h121);
    wr(3'd3, 12'h001);
    setWr(3'd3, 12'h010); step(3'b001, "R8");
    setWr(3'd3, 12'h040); step(3'b100, "R8");
    // R4 period zero disables
    wr(3'd3, 12'h004);
    wr(3'd1, 12'h021);
    cmpUp[0] = 1; step(3'b000, "R4");
    setWr(3'd3, 12'h040); step(3'b000, "R4");
    rdChk(3'd5, 12'h000, "R4");
    rdChk(3'd3, 12'h001, "R4");
    // R9 initial count load
    wr(3'd1, 12'h023);
    wr(3'd2, 12'h010);
    evZero = 1; step(3'b000, "R9");
    wr(3'd4, 12'h002);
    syncIn = 1; step(3'b000, "R9");
    rdChk(3'd5, 12'h011, "R9");
    evPrd = 1; step(3'b010, "R9");
    wr(3'd3, 12'h200);
    rdChk(3'd5, 12'h011, "R9");
    evPrd = 1; setWr(3'd3, 12'h200); step(3'b000, "R9");
    rdChk(3'd5, 12'h011, "R9");
    // R5 saturation above period
    wr(3'd2, 12'h0C0);
    wr(3'd3, 12'h200);
    for (int k = 0; k < 4; k++) begin
      evPrd = 1; step(3'b000, "R5");
    end
    rdChk(3'd5, 12'h0F1, "R5");
    // R11 digital-compare sources
    wr(3'd0, 12'hCCC);
    wr(3'd1, 12'h111);
    wr(3'd2, 12'h000);
    wr(3'd3, 12'h701);
    rdChk(3'd5, 12'h000, "R11");
    dcSoc = 2'b01; step(3'b010, "R11");
    dcSoc = 2'b10; step(3'b100, "R11");
    dcSoc = 2'b11; step(3'b110, "R11");
    rdChk(3'd5, 12'h000, "R11");
    // R2 more source codes
    wr(3'd0, 12'hB03);
    evPrd = 1; step(3'b001, "R2");
    cmpDn[3] = 1; step(3'b100, "R2");
    cmpUp[3] = 1; step(3'b000, "R2");

    repeat (3) step(3'b000, "R3");
    while (expQ.size() > 0) begin
      checks++; errors++;
      $display("FAIL %s: ch%0d actual=no pulse expected=pulse", expQ[0].req, expQ[0].ch);
      void'(expQ.pop_front());
    end
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule